// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register and command front end of an eight-input priority interrupt controller. A host reaches it through one address bit and an 8-bit data bus with single-cycle write and read strobes. Writes start and step an initialization sequence of up to four words, or they issue operation commands. These commands load the line mask, retire in-service lines, rotate the priority order, set poll mode, choose which status register a read returns, and switch special mask mode on or off. Reads return status, or they perform a polled acknowledge.

The request register lives in a separate latch. This block takes it in as `req_in`, together with the per-line trigger mode. It sends back a one-cycle clear pulse for each bit the latch must forget. A small rotating priority encoder is built in. It finds the winning pending line for poll reads and the top in-service line for a non-specific end-of-interrupt. A specific end-of-interrupt is announced on a one-cycle notification with the global line number.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset, mask, in-service set, priority offset, vector base, auto-EOI, special fully nested, special mask and init-busy are all zero. A read with `bus_a0`=0 returns `req_in`.
- R2: A write with `bus_a0`=0 and data bit 4 set starts initialization. It clears mask, in-service, offset, rotate-on-auto-EOI, special mask, read-select and poll, and it sets `init_busy_o`. In the next cycle `req_clr_o` equals `~level_mode` for exactly one cycle. Auto-EOI and special fully nested are cleared only when data bit 0 is 0.
- R3: During initialization, the first `bus_a0`=1 write loads `vec_base_o` with data AND 8'hF8. If ICW1 data bit 1 was set (single), the third word is skipped. The fourth word is expected only if ICW1 bit 0 was set. `init_busy_o` falls after the last expected word.
- R4: The fourth initialization word sets special fully nested from data bit 4 and auto-EOI from data bit 1.
- R5: A `bus_a0`=1 write loads the mask only when no initialization is in progress. Words written during initialization leave the mask unchanged.
- R6: A write with `bus_a0`=0, bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll. If bit 1 is set, read-select takes bit 0. If bit 6 is set, special mask takes bit 5.
- R7: `bus_rdata` is registered and valid the cycle after `bus_rd`. With `bus_a0`=1 it returns the mask. With `bus_a0`=0 it returns the in-service set when read-select is 1, and `req_in` when read-select is 0.
- R8: A read while poll is armed disarms poll. The winner is the highest-priority unmasked request that outranks the highest in-service line; in special mask mode, masked in-service lines are ignored. If there is a winner, the read returns its line number in bits 2..0 with the upper bits zero, and the line is acknowledged. Acknowledging sets its in-service bit, unless auto-EOI is on; with auto-EOI and rotate on, the offset becomes line+1 instead. The line's bit is pulsed on `req_clr_o` if it is edge-triggered (`level_mode` bit 0). If there is no winner, the read returns 8'hFF.
- R9: Line (offset+k) mod 8 has rank k, and rank 0 is the highest priority.
- R10: A write with `bus_a0`=0 and bits 4..3 = 00 is a command with code bits 7..5. Code 1 clears the highest-priority in-service bit, skipping masked bits in special mask mode. Code 5 does the same and then sets the offset to that line+1.
- R11: Codes 3 and 7 clear the in-service bit given by data bits 2..0, and code 7 also sets the offset to that line+1. In the next cycle `eoi_stb_o` pulses for one cycle with `eoi_line_o` = line + 8 on a slave instance and = line on a master.
- R12: Code 6 sets the offset to data bits 2..0 plus 1, mod 8. Codes 0 and 4 clear or set rotate-on-auto-EOI. Code 2 changes nothing.
- R13: On a master with special fully nested set, a pending cascade line (line 2) is not blocked by its own in-service bit. On a slave this exception does not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_a0 | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| req_in | input | 8 | Request register from the request latch |
| level_mode | input | 8 | Per-line trigger mode, 1 = level |
| mask_o | output | 8 | Line mask |
| insvc_o | output | 8 | In-service set |
| prio_off_o | output | 3 | Priority offset (line holding rank 0) |
| vec_base_o | output | 8 | Vector base |
| auto_eoi_o | output | 1 | Auto-EOI mode |
| sfn_o | output | 1 | Special fully nested mode |
| spec_mask_o | output | 1 | Special mask mode |
| init_busy_o | output | 1 | Initialization sequence in progress |
| req_clr_o | output | 8 | One-cycle clear pulses toward the request latch |
| eoi_stb_o | output | 1 | Specific end-of-interrupt notification |
| eoi_line_o | output | 4 | Global line number of the notification |

## Verification
The bench targets the places where rotation and masking interact. It reads with the offset moved, so that a decoder ranking lines from zero returns the wrong winner. It retires a line in special mask mode while a masked line is also in service, so that a decoder ignoring that mode clears the masked line instead. It runs a poll that must come back empty because a higher line is in service, and it then reads again to confirm that poll was disarmed. It walks initialization in single mode without the fourth word, where a sequencer that did not skip words would keep swallowing the next mask write. It also runs the auto-EOI rotating acknowledge, where the offset must move while the in-service set stays empty. Finally, it drives a master and a slave side by side for the cascade exception and the +8 notification.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

   typedef enum logic [1:0] {
      INIT_IDLE = 2'd0,
      INIT_BASE = 2'd1,
      INIT_CASC = 2'd2,
      INIT_MODE = 2'd3
   } init_st_e;

   localparam logic [2:0] CMD_ROT_CLR    = 3'd0;
   localparam logic [2:0] CMD_NS_EOI     = 3'd1;
   localparam logic [2:0] CMD_NOP        = 3'd2;
   localparam logic [2:0] CMD_SP_EOI     = 3'd3;
   localparam logic [2:0] CMD_ROT_SET    = 3'd4;
   localparam logic [2:0] CMD_NS_EOI_ROT = 3'd5;
   localparam logic [2:0] CMD_SET_PRIO   = 3'd6;
   localparam logic [2:0] CMD_SP_EOI_ROT = 3'd7;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NLINES = 8,
   localparam int LW = $clog2(NLINES)
) (
   input  logic [NLINES-1:0] cand,
   input  logic [LW-1:0]     offset,
   output logic              hit,
   output logic [LW-1:0]     line,
   output logic [LW-1:0]     rank
);
   generate
      if (NLINES < 2) begin : g_bad
         $error("irq_prio_pick: NLINES must be at least 2");
      end
   endgenerate

   always_comb begin
      hit  = 1'b0;
      line = '0;
      rank = '0;
      for (int k = NLINES - 1; k >= 0; k--) begin
         logic [LW-1:0] idx;
         idx = offset + LW'(k);
         if (cand[idx]) begin
            hit  = 1'b1;
            line = idx;
            rank = LW'(k);
         end
      end
   end
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
   import irq_cmd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     single_i,
   input  logic     need_mode_i,
   input  logic     step,
   output init_st_e state
);
   logic single_q;
   logic need_mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= INIT_IDLE;
         single_q    <= 1'b0;
         need_mode_q <= 1'b0;
      end else if (start) begin
         state       <= INIT_BASE;
         single_q    <= single_i;
         need_mode_q <= need_mode_i;
      end else if (step) begin
         case (state)
            INIT_BASE: state <= single_q ? (need_mode_q ? INIT_MODE : INIT_IDLE) : INIT_CASC;
            INIT_CASC: state <= need_mode_q ? INIT_MODE : INIT_IDLE;
            INIT_MODE: state <= INIT_IDLE;
            default:   state <= INIT_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
   import irq_cmd_pkg::*;
#(
   parameter int NLINES    = 8,
   parameter int DW        = 8,
   parameter bit IS_SLAVE  = 1'b0,
   parameter int CASC_LINE = 2,
   localparam int LW = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_a0,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NLINES-1:0] req_in,
   input  logic [NLINES-1:0] level_mode,
   output logic [NLINES-1:0] mask_o,
   output logic [NLINES-1:0] insvc_o,
   output logic [LW-1:0]     prio_off_o,
   output logic [DW-1:0]     vec_base_o,
   output logic              auto_eoi_o,
   output logic              sfn_o,
   output logic              spec_mask_o,
   output logic              init_busy_o,
   output logic [NLINES-1:0] req_clr_o,
   output logic              eoi_stb_o,
   output logic [LW:0]       eoi_line_o
);
   localparam logic [DW-1:0] BASE_KEEP = DW'(8'hF8);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("irq_cmd_decoder: command fields need an 8-bit bus");
      end
      if (NLINES < 2 || NLINES > 8 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_n
         $error("irq_cmd_decoder: NLINES must be a power of two from 2 to 8");
      end
   endgenerate

   // command decode
   logic wr_cmd, is_init1, is_mode, is_op, wr_data;
   assign wr_cmd   = bus_wr & ~bus_a0;
   assign is_init1 = wr_cmd & bus_wdata[4];
   assign is_mode  = wr_cmd & ~bus_wdata[4] & bus_wdata[3];
   assign is_op    = wr_cmd & ~bus_wdata[4] & ~bus_wdata[3];
   assign wr_data  = bus_wr & bus_a0;

   logic [NLINES-1:0] imr, isr;
   logic [LW-1:0]     off;
   logic              rot_aeoi, smm, rsel, poll, aeoi, sfn;
   init_st_e          init_st;

   irq_init_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (is_init1),
      .single_i   (bus_wdata[1]),
      .need_mode_i(bus_wdata[0]),
      .step       (wr_data),
      .state      (init_st)
   );

   // pending winner
   logic          pend_hit;
   logic [LW-1:0] pend_line, pend_rank;
   irq_prio_pick #(.NLINES(NLINES)) u_pend (
      .cand(req_in & ~imr), .offset(off),
      .hit(pend_hit), .line(pend_line), .rank(pend_rank)
   );

   // in-service set relevant to masking: special mask hides masked lines
   logic [NLINES-1:0] isr_vis;
   assign isr_vis = smm ? (isr & ~imr) : isr;

   // cascade exception only on a master
   logic [NLINES-1:0] casc_hide;
   generate
      if (!IS_SLAVE && CASC_LINE < NLINES) begin : g_master
         assign casc_hide = (sfn && pend_line == LW'(CASC_LINE)) ?
                            (NLINES'(1) << CASC_LINE) : '0;
      end else begin : g_slave
         assign casc_hide = '0;
      end
   endgenerate

   logic          blk_hit;
   logic [LW-1:0] blk_line, blk_rank;
   irq_prio_pick #(.NLINES(NLINES)) u_block (
      .cand(isr_vis & ~casc_hide), .offset(off),
      .hit(blk_hit), .line(blk_line), .rank(blk_rank)
   );

   logic          top_hit;
   logic [LW-1:0] top_line, top_rank;
   irq_prio_pick #(.NLINES(NLINES)) u_top (
      .cand(isr_vis), .offset(off),
      .hit(top_hit), .line(top_line), .rank(top_rank)
   );

   logic win;
   assign win = pend_hit && (!blk_hit || pend_rank < blk_rank);

   logic [LW-1:0] sel_line;
   assign sel_line = bus_wdata[LW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr        <= '0;
         isr        <= '0;
         off        <= '0;
         rot_aeoi   <= 1'b0;
         smm        <= 1'b0;
         rsel       <= 1'b0;
         poll       <= 1'b0;
         aeoi       <= 1'b0;
         sfn        <= 1'b0;
         vec_base_o <= '0;
         bus_rdata  <= '0;
         req_clr_o  <= '0;
         eoi_stb_o  <= 1'b0;
         eoi_line_o <= '0;
      end else begin
         req_clr_o <= '0;
         eoi_stb_o <= 1'b0;
         if (is_init1) begin
            imr       <= '0;
            isr       <= '0;
            off       <= '0;
            rot_aeoi  <= 1'b0;
            smm       <= 1'b0;
            rsel      <= 1'b0;
            poll      <= 1'b0;
            req_clr_o <= ~level_mode;
            if (!bus_wdata[0]) begin
               aeoi <= 1'b0;
               sfn  <= 1'b0;
            end
         end else if (is_mode) begin
            if (bus_wdata[2]) poll <= 1'b1;
            if (bus_wdata[1]) rsel <= bus_wdata[0];
            if (bus_wdata[6]) smm  <= bus_wdata[5];
         end else if (is_op) begin
            case (bus_wdata[7:5])
               CMD_ROT_CLR:  rot_aeoi <= 1'b0;
               CMD_ROT_SET:  rot_aeoi <= 1'b1;
               CMD_NS_EOI, CMD_NS_EOI_ROT: begin
                  if (top_hit) begin
                     isr[top_line] <= 1'b0;
                     if (bus_wdata[7]) off <= top_line + 1'b1;
                  end
               end
               CMD_SP_EOI, CMD_SP_EOI_ROT: begin
                  isr[sel_line] <= 1'b0;
                  if (bus_wdata[7]) off <= sel_line + 1'b1;
                  eoi_stb_o  <= 1'b1;
                  eoi_line_o <= {IS_SLAVE, sel_line};
               end
               CMD_SET_PRIO: off <= sel_line + 1'b1;
               default: ;
            endcase
         end else if (wr_data) begin
            case (init_st)
               INIT_IDLE: imr        <= bus_wdata[NLINES-1:0];
               INIT_BASE: vec_base_o <= bus_wdata & BASE_KEEP;
               INIT_MODE: begin
                  sfn  <= bus_wdata[4];
                  aeoi <= bus_wdata[1];
               end
               default: ;
            endcase
         end else if (bus_rd) begin
            if (poll) begin
               poll <= 1'b0;
               if (win) begin
                  bus_rdata <= DW'(pend_line);
                  if (!aeoi)         isr[pend_line] <= 1'b1;
                  else if (rot_aeoi) off <= pend_line + 1'b1;
                  req_clr_o[pend_line] <= ~level_mode[pend_line];
               end else begin
                  bus_rdata <= '1;
               end
            end else if (bus_a0) begin
               bus_rdata <= DW'(imr);
            end else begin
               bus_rdata <= rsel ? DW'(isr) : DW'(req_in);
            end
         end
      end
   end

   assign mask_o      = imr;
   assign insvc_o     = isr;
   assign prio_off_o  = off;
   assign auto_eoi_o  = aeoi;
   assign sfn_o       = sfn;
   assign spec_mask_o = smm;
   assign init_busy_o = (init_st != INIT_IDLE);
endmodule

// File: rtl/irq_cmd_decoder_chk.sv
module irq_cmd_decoder_chk #(
   parameter int NLINES = 8,
   parameter int DW     = 8,
   localparam int LW = $clog2(NLINES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_a0,
   input logic [DW-1:0]     bus_wdata,
   input logic [NLINES-1:0] mask_o,
   input logic [NLINES-1:0] insvc_o,
   input logic [LW-1:0]     prio_off_o,
   input logic              init_busy_o,
   input logic [NLINES-1:0] req_clr_o,
   input logic              eoi_stb_o
);
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_a0 && bus_wdata[4]) |=>
      (mask_o == '0 && insvc_o == '0 && prio_off_o == '0 && init_busy_o)); // R2

   AST_REQ_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_clr_o) |-> $past(bus_wr || bus_rd)); // R2

   AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_busy_o) |-> $past(bus_wr && !bus_a0)); // R3

   AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr) |-> $stable(mask_o)); // R5

   AST_INSVC_SET_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (|(insvc_o & ~$past(insvc_o))) |-> $past(bus_rd)); // R8

   AST_EOI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_stb_o |-> $past(bus_wr && !bus_a0 && bus_wdata[4:3] == 2'b00
                          && bus_wdata[6:5] == 2'b11)); // R11
endmodule

bind irq_cmd_decoder irq_cmd_decoder_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_a0     (bus_a0),
   .bus_wdata  (bus_wdata),
   .mask_o     (mask_o),
   .insvc_o    (insvc_o),
   .prio_off_o (prio_off_o),
   .init_busy_o(init_busy_o),
   .req_clr_o  (req_clr_o),
   .eoi_stb_o  (eoi_stb_o)
);

// File: tb/irq_cmd_decoder_bench.sv
module irq_cmd_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 43;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
   logic [7:0] bus_wdata = '0, req_in = '0, level_mode = '0;
   logic [7:0] rdata_m, mask_m, isr_m, base_m, clr_m;
   logic [7:0] rdata_s, mask_s, isr_s, base_s, clr_s;
   logic [2:0] off_m, off_s;
   logic       aeoi_m, sfn_m, smm_m, busy_m, eoi_m;
   logic       aeoi_s, sfn_s, smm_s, busy_s, eoi_s;
   logic [3:0] eline_m, eline_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_cmd_decoder u_irq_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .req_in(req_in), .level_mode(level_mode),
      .mask_o(mask_m), .insvc_o(isr_m), .prio_off_o(off_m), .vec_base_o(base_m),
      .auto_eoi_o(aeoi_m), .sfn_o(sfn_m), .spec_mask_o(smm_m), .init_busy_o(busy_m),
      .req_clr_o(clr_m), .eoi_stb_o(eoi_m), .eoi_line_o(eline_m)
   );

   irq_cmd_decoder #(.IS_SLAVE(1'b1)) u_irq_cmd_decoder_slv (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .req_in(req_in), .level_mode(level_mode),
      .mask_o(mask_s), .insvc_o(isr_s), .prio_off_o(off_s), .vec_base_o(base_s),
      .auto_eoi_o(aeoi_s), .sfn_o(sfn_s), .spec_mask_o(smm_s), .init_busy_o(busy_s),
      .req_clr_o(clr_s), .eoi_stb_o(eoi_s), .eoi_line_o(eline_s)
   );

   // vector: {is_write, a0, data, req, expected read, requirement number}
   localparam logic [33:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'h11, 8'h00, 8'h00, 8'd2},   // R2 start, cascade, fourth word
      {1'b1, 1'b1, 8'h20, 8'h00, 8'h00, 8'd3},   // R3 base
      {1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'd3},   // R3 cascade word
      {1'b1, 1'b1, 8'h01, 8'h00, 8'h00, 8'd4},   // R4 mode word
      {1'b1, 1'b1, 8'h0F, 8'h00, 8'h00, 8'd5},   // R5 mask
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h0F, 8'd7},   // R7 mask read
      {1'b0, 1'b0, 8'h00, 8'h5A, 8'h5A, 8'd7},   // R7 request read
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},   // R6 poll
      {1'b0, 1'b0, 8'h00, 8'h30, 8'h04, 8'd8},   // R8 winner line 4
      {1'b1, 1'b0, 8'h0B, 8'h00, 8'h00, 8'd6},   // R6 read-select 1
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 8'd7},
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h20, 8'hFF, 8'd8},   // R8 blocked by in-service
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 8'd8},   // R8 poll disarmed
      {1'b1, 1'b0, 8'h20, 8'h00, 8'h00, 8'd10},  // R10 non-specific
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'd10},
      {1'b1, 1'b0, 8'hC5, 8'h00, 8'h00, 8'd12},  // R12 offset 6
      {1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'd5},
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h81, 8'h07, 8'd9},   // R9 line 7 ranks above 0
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h40, 8'h06, 8'd9},   // R9 line 6 is rank 0
      {1'b0, 1'b0, 8'h00, 8'h00, 8'hC0, 8'd8},
      {1'b1, 1'b0, 8'h67, 8'h00, 8'h00, 8'd11},  // R11 specific line 7
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h40, 8'd11},
      {1'b1, 1'b0, 8'hE6, 8'h00, 8'h00, 8'd11},  // R11 specific line 6 rotate
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'd11},
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h81, 8'h07, 8'd11},  // offset 7 after rotate
      {1'b1, 1'b0, 8'hA0, 8'h00, 8'h00, 8'd10},  // R10 code 5
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h81, 8'h00, 8'd10},  // offset 0 after rotate
      {1'b1, 1'b0, 8'h40, 8'h00, 8'h00, 8'd12},  // R12 code 2
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 8'd12},
      {1'b1, 1'b1, 8'h01, 8'h00, 8'h00, 8'd5},
      {1'b1, 1'b0, 8'h68, 8'h00, 8'h00, 8'd6},   // R6 special mask on
      {1'b1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'd6},
      {1'b0, 1'b0, 8'h00, 8'h02, 8'h01, 8'd8},   // R8 masked in-service ignored
      {1'b1, 1'b0, 8'h20, 8'h00, 8'h00, 8'd10},  // R10 skips masked line 0
      {1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 8'd10},
      {1'b1, 1'b0, 8'h0A, 8'h00, 8'h00, 8'd6},   // R6 read-select 0
      {1'b0, 1'b0, 8'h00, 8'h33, 8'h33, 8'd6},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h01, 8'd7}
   };

   task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic do_wr(input logic a0, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic a0, input logic [7:0] rq);
      @(negedge clk);
      bus_rd = 1'b1; bus_a0 = a0; req_in = rq;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; level_mode = '0; req_in = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 mask", mask_m, 8'h00);
      chk("R1 insvc", isr_m, 8'h00);
      chk("R1 offset", {5'd0, off_m}, 8'h00);
      chk("R1 base", base_m, 8'h00);
      chk("R1 flags", {3'd0, aeoi_m, sfn_m, smm_m, busy_m, eoi_m}, 8'h00);
      do_rd(1'b0, 8'hA5);
      chk("R1 read request", rdata_m, 8'hA5);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][33]) do_wr(VEC[i][32], VEC[i][31:24]);
         else begin
            do_rd(VEC[i][32], VEC[i][23:16]);
            chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), rdata_m, VEC[i][15:8]);
         end
      end

      // R3 single mode, no fourth word; R5 mask then loads
      do_reset();
      do_wr(1'b0, 8'h12);
      chk("R3 busy after start", {7'd0, busy_m}, 8'h01);
      do_wr(1'b1, 8'h4D);
      chk("R3 base masked", base_m, 8'h48);
      chk("R3 done after base", {7'd0, busy_m}, 8'h00);
      do_wr(1'b1, 8'h33);
      chk("R5 mask after init", mask_m, 8'h33);

      // R2 clear pulse; R5 mask untouched during init
      level_mode = 8'hF0;
      do_wr(1'b0, 8'h12);
      chk("R2 req_clr pulse", clr_m, 8'h0F);
      chk("R2 mask cleared", mask_m, 8'h00);
      @(negedge clk);
      chk("R2 req_clr one cycle", clr_m, 8'h00);
      do_wr(1'b1, 8'h99);
      chk("R5 mask held in init", mask_m, 8'h00);
      chk("R3 base second", base_m, 8'h98);
      level_mode = 8'h00;

      // R4 mode word; R2 keeps mode flags when bit 0 set
      do_wr(1'b0, 8'h13);
      do_wr(1'b1, 8'h08);
      chk("R3 waits mode word", {7'd0, busy_m}, 8'h01);
      do_wr(1'b1, 8'h12);
      chk("R4 sfn and aeoi", {6'd0, sfn_m, aeoi_m}, 8'h03);
      chk("R4 done", {7'd0, busy_m}, 8'h00);
      do_wr(1'b0, 8'h13);
      chk("R2 keeps aeoi", {6'd0, sfn_m, aeoi_m}, 8'h03);
      do_wr(1'b1, 8'h00);
      do_wr(1'b1, 8'h12);
      do_wr(1'b0, 8'h12);
      chk("R2 clears aeoi", {6'd0, sfn_m, aeoi_m}, 8'h00);
      do_wr(1'b1, 8'h00);

      // R8 auto-EOI rotating acknowledge
      do_reset();
      do_wr(1'b0, 8'h13); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h02);
      do_wr(1'b0, 8'h80);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, 8'h08);
      chk("R8 aeoi poll line", rdata_m, 8'h03);
      chk("R8 aeoi no insvc", isr_m, 8'h00);
      chk("R8 req_clr edge line", clr_m, 8'h08);
      chk("R8 rotate offset", {5'd0, off_m}, 8'h04);
      do_wr(1'b0, 8'h00);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, 8'h10);
      chk("R12 rotate cleared line", rdata_m, 8'h04);
      chk("R12 offset kept", {5'd0, off_m}, 8'h04);

      // R11 notification, master and slave
      do_wr(1'b0, 8'h65);
      chk("R11 eoi strobe", {7'd0, eoi_m}, 8'h01);
      chk("R11 master line", {4'd0, eline_m}, 8'h05);
      chk("R11 slave line", {4'd0, eline_s}, 8'h0D);
      @(negedge clk);
      chk("R11 strobe one cycle", {7'd0, eoi_m}, 8'h00);

      // R12 set priority
      do_wr(1'b0, 8'hC2);
      chk("R12 set priority", {5'd0, off_m}, 8'h03);

      // R13 cascade line under special fully nested
      do_reset();
      do_wr(1'b0, 8'h11); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h10);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, 8'h04);
      chk("R13 first ack", rdata_m, 8'h02);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, 8'h04);
      chk("R13 master nests cascade", rdata_m, 8'h02);
      chk("R13 slave blocked", rdata_s, 8'hFF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule